// File: doc/BRIEF.md
# Radio-Set Clock with Mains Fallback

This block keeps the time of day as six BCD digits (hours, minutes and seconds, tens and units) and holds a set of date fields. A radio time decoder upstream gives it one pulse per second, a level that says whether the decoder is locked, a strobe that marks a freshly decoded frame, and the decoded hour, minute and date values. A mains-derived pulse train, one pulse per mains cycle, is the local reference.

When the decoder is locked, the radio pulses advance the seconds. When lock is lost, the block divides the mains pulses down to one per second and keeps counting without a gap. The mains divider and the radio pulse share one phase counter. That counter restarts at every accepted second, so the backup second falls one full second after the last radio second. The same counter also lets the block reject a radio pulse that comes too soon after a second already counted, so the change of source in either direction neither doubles nor drops a second. A decoded frame is captured when its strobe arrives and is applied on the next counted second. At that second the hours and minutes load, the seconds restart at 00, and the date fields are latched.

Top module: `fallback_clock`

## Requirements
- R1: After a synchronous reset, all six time digits read 00:00:00 and every date field reads zero.
- R2: On each counted second, the seconds units step 0 to 9 and then return to 0 with a carry into the tens. The tens step 0 to 5, and 59 seconds becomes 00 with a carry into the minutes.
- R3: The minutes wrap from 59 to 00 with a carry into the hours. The hours wrap from 23 to 00. Time digits are ordered {hr_t, hr_u, mn_t, mn_u, sc_t, sc_u}, 4 bits each.
- R4: While `sync_ok` is high, each accepted `radio_tick` advances the time by exactly one second, and mains pulses alone never advance it.
- R5: While `sync_ok` is low, `radio_tick` is ignored. The time advances once for every DIV mains pulses.
- R6: A `preset_stb` pulse captures the decoded fields. The next counted second loads the hours and minutes from them, sets the seconds to 00 and latches the date. Nothing changes before that second. If the strobe and a counted second fall in the same cycle, that second counts normally and the load happens at the following second.
- R7: The date outputs change only at a preset load, never through time counting, midnight included.
- R8: In locked mode, a radio pulse that arrives after fewer than GUARD mains pulses since the last counted second is ignored.
- R9: When lock is lost, the first backup second comes on the DIV-th mains pulse after the last counted radio second.
- R10: Changes on the decoded inputs after the strobe and before the load second do not affect the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| radio_tick | input | 1 | One-cycle pulse per received second |
| sync_ok | input | 1 | High while the radio decoder is locked |
| pulse_50hz | input | 1 | One-cycle pulse per mains cycle |
| preset_stb | input | 1 | One-cycle pulse: decoded fields are valid |
| dec_hr_t | input | 4 | Decoded hours tens (BCD) |
| dec_hr_u | input | 4 | Decoded hours units (BCD) |
| dec_mn_t | input | 4 | Decoded minutes tens (BCD) |
| dec_mn_u | input | 4 | Decoded minutes units (BCD) |
| dec_year | input | 8 | Decoded year, two BCD digits |
| dec_month | input | 5 | Decoded month, BCD |
| dec_mday | input | 6 | Decoded day of month, BCD |
| dec_wday | input | 3 | Decoded weekday, 0 = Sunday |
| hr_t | output | 4 | Hours tens |
| hr_u | output | 4 | Hours units |
| mn_t | output | 4 | Minutes tens |
| mn_u | output | 4 | Minutes units |
| sc_t | output | 4 | Seconds tens |
| sc_u | output | 4 | Seconds units |
| year | output | 8 | Latched year |
| month | output | 5 | Latched month |
| mday | output | 6 | Latched day of month |
| wday | output | 3 | Latched weekday |

## Verification
The hardest situations to reach are the changes of tick source: a radio pulse that lands a few mains pulses after a backup second, and a loss of lock whose first backup second must fall exactly DIV pulses after the last radio second. The bench uses a small divider (DIV of 5, GUARD of 3) and drives the mains pulses and radio pulses one at a time. This places each radio pulse at a chosen count of mains pulses after the last second, and the time is checked after every pulse on both sides of the guard limit. An hour-by-hour sweep presets each hour to hh:59:00 and runs past the rollover, reaching every hours carry including midnight.

// File: rtl/fbclk_pkg.sv
package fbclk_pkg;

    typedef logic [3:0] digit_t;

    typedef struct packed {
        digit_t hr_t;
        digit_t hr_u;
        digit_t mn_t;
        digit_t mn_u;
        digit_t sc_t;
        digit_t sc_u;
    } hms_t;

    typedef struct packed {
        logic [7:0] year;
        logic [4:0] month;
        logic [5:0] mday;
        logic [2:0] wday;
    } date_t;

    typedef enum logic {
        SRC_RADIO  = 1'b0,
        SRC_BACKUP = 1'b1
    } src_e;

    // Next value of a BCD digit that wraps after 'last'
    function automatic digit_t digit_step(digit_t d, digit_t last);
        return (d == last) ? 4'd0 : d + 4'd1;
    endfunction

endpackage

// File: rtl/tick_select.sv
module tick_select
    import fbclk_pkg::*;
#(
    parameter int DIV   = 50,
    parameter int GUARD = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_ok,
    input  logic radio_tick,
    input  logic pulse_50hz,
    output logic tick,
    output src_e src
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
    localparam logic [CW-1:0] GMIN  = CW'(GUARD);

    // mains pulses seen since the last counted second, saturating
    logic [CW-1:0] phase_q;
    logic          radio_ok;
    logic          backup_ok;

    always_comb begin
        src       = sync_ok ? SRC_RADIO : SRC_BACKUP;
        radio_ok  = (src == SRC_RADIO)  && radio_tick && (phase_q >= GMIN);
        backup_ok = (src == SRC_BACKUP) && pulse_50hz && (phase_q == LAST);
        tick      = radio_ok || backup_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= LAST;
        end else if (tick) begin
            phase_q <= '0;
        end else if (pulse_50hz && phase_q != LAST) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/preset_hold.sv
module preset_hold
    import fbclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  preset_stb,
    input  logic  tick,
    input  hms_t  dec_time,
    input  date_t dec_date,
    output logic  pending,
    output hms_t  held_time,
    output date_t held_date
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            held_time <= '0;
            held_date <= '0;
        end else if (preset_stb) begin
            pending   <= 1'b1;
            held_time <= dec_time;
            held_date <= dec_date;
        end else if (tick) begin
            pending   <= 1'b0;
        end
    end

endmodule

// File: rtl/sexa_stage.sv
module sexa_stage
    import fbclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   inc,
    input  logic   load,
    input  digit_t ld_t,
    input  digit_t ld_u,
    output digit_t t,
    output digit_t u,
    output logic   carry
);
    logic u_wrap;

    always_comb begin
        u_wrap = (u == 4'd9);
        carry  = inc && u_wrap && (t == 4'd5);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t <= '0;
            u <= '0;
        end else if (load) begin
            t <= ld_t;
            u <= ld_u;
        end else if (inc) begin
            u <= digit_step(u, 4'd9);
            if (u_wrap) t <= digit_step(t, 4'd5);
        end
    end

endmodule

// File: rtl/time_core.sv
module time_core
    import fbclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  hms_t load_val,
    output hms_t cur
);
    localparam int NSTAGE = 2;   // seconds, minutes

    logic   [NSTAGE:0]   inc_chain;
    digit_t [NSTAGE-1:0] ld_t, ld_u, st_t, st_u;

    assign inc_chain[0] = tick && !load;
    assign ld_t[0] = 4'd0;
    assign ld_u[0] = 4'd0;
    assign ld_t[1] = load_val.mn_t;
    assign ld_u[1] = load_val.mn_u;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        sexa_stage u_stage (
            .clk  (clk),
            .rst  (rst),
            .inc  (inc_chain[g]),
            .load (load),
            .ld_t (ld_t[g]),
            .ld_u (ld_u[g]),
            .t    (st_t[g]),
            .u    (st_u[g]),
            .carry(inc_chain[g+1])
        );
    end

    digit_t hr_t_q, hr_u_q;
    logic   hr_inc, hr_top, hr_u_wrap;

    always_comb begin
        hr_inc    = inc_chain[NSTAGE];
        hr_top    = (hr_t_q == 4'd2) && (hr_u_q == 4'd3);
        hr_u_wrap = (hr_u_q == 4'd9);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hr_t_q <= '0;
            hr_u_q <= '0;
        end else if (load) begin
            hr_t_q <= load_val.hr_t;
            hr_u_q <= load_val.hr_u;
        end else if (hr_inc) begin
            if (hr_top) begin
                hr_t_q <= '0;
                hr_u_q <= '0;
            end else begin
                hr_u_q <= digit_step(hr_u_q, 4'd9);
                if (hr_u_wrap) hr_t_q <= hr_t_q + 4'd1;
            end
        end
    end

    always_comb begin
        cur.hr_t = hr_t_q;
        cur.hr_u = hr_u_q;
        cur.mn_t = st_t[1];
        cur.mn_u = st_u[1];
        cur.sc_t = st_t[0];
        cur.sc_u = st_u[0];
    end

endmodule

// File: rtl/fallback_clock.sv
module fallback_clock
    import fbclk_pkg::*;
#(
    parameter int DIV   = 50,
    parameter int GUARD = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       radio_tick,
    input  logic       sync_ok,
    input  logic       pulse_50hz,
    input  logic       preset_stb,
    input  logic [3:0] dec_hr_t,
    input  logic [3:0] dec_hr_u,
    input  logic [3:0] dec_mn_t,
    input  logic [3:0] dec_mn_u,
    input  logic [7:0] dec_year,
    input  logic [4:0] dec_month,
    input  logic [5:0] dec_mday,
    input  logic [2:0] dec_wday,
    output logic [3:0] hr_t,
    output logic [3:0] hr_u,
    output logic [3:0] mn_t,
    output logic [3:0] mn_u,
    output logic [3:0] sc_t,
    output logic [3:0] sc_u,
    output logic [7:0] year,
    output logic [4:0] month,
    output logic [5:0] mday,
    output logic [2:0] wday
);
    logic  tick;
    src_e  src;
    logic  pending;
    logic  load;
    hms_t  dec_time, held_time, cur;
    date_t dec_date, held_date, date_q;

    always_comb begin
        dec_time = '{hr_t: dec_hr_t, hr_u: dec_hr_u, mn_t: dec_mn_t,
                     mn_u: dec_mn_u, sc_t: 4'd0, sc_u: 4'd0};
        dec_date = '{year: dec_year, month: dec_month,
                     mday: dec_mday, wday: dec_wday};
        load     = tick && pending;
    end

    tick_select #(.DIV(DIV), .GUARD(GUARD)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .sync_ok   (sync_ok),
        .radio_tick(radio_tick),
        .pulse_50hz(pulse_50hz),
        .tick      (tick),
        .src       (src)
    );

    preset_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .preset_stb(preset_stb),
        .tick      (tick),
        .dec_time  (dec_time),
        .dec_date  (dec_date),
        .pending   (pending),
        .held_time (held_time),
        .held_date (held_date)
    );

    time_core u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (load),
        .load_val(held_time),
        .cur     (cur)
    );

    always_ff @(posedge clk) begin
        if (rst)       date_q <= '0;
        else if (load) date_q <= held_date;
    end

    always_comb begin
        hr_t  = cur.hr_t;
        hr_u  = cur.hr_u;
        mn_t  = cur.mn_t;
        mn_u  = cur.mn_u;
        sc_t  = cur.sc_t;
        sc_u  = cur.sc_u;
        year  = date_q.year;
        month = date_q.month;
        mday  = date_q.mday;
        wday  = date_q.wday;
    end

endmodule

// File: rtl/fallback_clock_chk.sv
module fallback_clock_chk #(
    parameter int DIV   = 50,
    parameter int GUARD = 25
) (
    input logic        clk,
    input logic        rst,
    input logic        sync_ok,
    input logic        pulse_50hz,
    input logic        tick,
    input logic        load,
    input logic [23:0] hms,
    input logic [21:0] date
);
    int unsigned since_q;

    always_ff @(posedge clk) begin
        if (rst)                               since_q <= DIV - 1;
        else if (tick)                         since_q <= 0;
        else if (pulse_50hz && since_q < DIV - 1) since_q <= since_q + 1;
    end

    // R2
    sec_range_chk: assert property (@(posedge clk) disable iff (rst)
        hms[3:0] <= 4'd9 && hms[7:4] <= 4'd5);

    // R3
    hm_range_chk: assert property (@(posedge clk) disable iff (rst)
        hms[11:8] <= 4'd9 && hms[15:12] <= 4'd5 && hms[19:16] <= 4'd9 &&
        (hms[23:20] < 4'd2 || (hms[23:20] == 4'd2 && hms[19:16] <= 4'd3)));

    // R4
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(hms));

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && hms[7:0] == 8'h59) |=> hms[7:0] == 8'h00);

    // R6
    load_zero_sec_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> hms[7:0] == 8'h00);

    // R7
    date_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(date));

    // R8
    guard_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && sync_ok) |-> since_q >= GUARD);

    // R9
    backup_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !sync_ok) |-> (pulse_50hz && since_q == DIV - 1));

endmodule

bind fallback_clock fallback_clock_chk #(.DIV(DIV), .GUARD(GUARD)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_ok   (sync_ok),
    .pulse_50hz(pulse_50hz),
    .tick      (tick),
    .load      (load),
    .hms       ({hr_t, hr_u, mn_t, mn_u, sc_t, sc_u}),
    .date      ({year, month, mday, wday})
);

// File: tb/fallback_clock_tb.sv
module fallback_clock_tb;
    localparam int DIV   = 5;
    localparam int GUARD = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic       radio_tick = 1'b0, sync_ok = 1'b1, pulse_50hz = 1'b0, preset_stb = 1'b0;
    logic [3:0] dec_hr_t = '0, dec_hr_u = '0, dec_mn_t = '0, dec_mn_u = '0;
    logic [7:0] dec_year = '0;
    logic [4:0] dec_month = '0;
    logic [5:0] dec_mday = '0;
    logic [2:0] dec_wday = '0;
    logic [3:0] hr_t, hr_u, mn_t, mn_u, sc_t, sc_u;
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] mday;
    logic [2:0] wday;

    fallback_clock #(.DIV(DIV), .GUARD(GUARD)) u_dut (
        .clk(clk), .rst(rst), .radio_tick(radio_tick), .sync_ok(sync_ok),
        .pulse_50hz(pulse_50hz), .preset_stb(preset_stb),
        .dec_hr_t(dec_hr_t), .dec_hr_u(dec_hr_u), .dec_mn_t(dec_mn_t), .dec_mn_u(dec_mn_u),
        .dec_year(dec_year), .dec_month(dec_month), .dec_mday(dec_mday), .dec_wday(dec_wday),
        .hr_t(hr_t), .hr_u(hr_u), .mn_t(mn_t), .mn_u(mn_u), .sc_t(sc_t), .sc_u(sc_u),
        .year(year), .month(month), .mday(mday), .wday(wday)
    );

    int  errors = 0;
    int  checks = 0;
    int  exp_s  = 0;
    bit  done   = 0;

    wire [23:0] cur_hms  = {hr_t, hr_u, mn_t, mn_u, sc_t, sc_u};
    wire [21:0] cur_date = {year, month, mday, wday};

    function automatic logic [23:0] bcd_of(int s);
        int h = s / 3600, m = (s / 60) % 60, x = s % 60;
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(x / 10), 4'(x % 10)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse50();
        @(negedge clk) pulse_50hz = 1'b1;
        @(negedge clk) pulse_50hz = 1'b0;
    endtask

    task automatic rtick();
        @(negedge clk) radio_tick = 1'b1;
        @(negedge clk) radio_tick = 1'b0;
    endtask

    task automatic radio_second();
        repeat (DIV) pulse50();
        rtick();
    endtask

    task automatic strobe(int h, int m, logic [21:0] d);
        @(negedge clk);
        dec_hr_t = 4'(h / 10); dec_hr_u = 4'(h % 10);
        dec_mn_t = 4'(m / 10); dec_mn_u = 4'(m % 10);
        {dec_year, dec_month, dec_mday, dec_wday} = d;
        preset_stb = 1'b1;
        @(negedge clk) preset_stb = 1'b0;
    endtask

    localparam logic [21:0] DATE_A = {8'h91, 5'h03, 6'h14, 3'd4};
    localparam logic [21:0] DATE_B = {8'h07, 5'h12, 6'h31, 3'd1};

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 time", cur_hms, 24'h0);
        check("R1 date", cur_date, 22'h0);

        // R4: mains pulses alone in locked mode
        repeat (2 * DIV) pulse50();
        check("R4 pulses no advance", cur_hms, 24'h0);

        // R4, R2: radio seconds 0..12
        for (int i = 0; i < 12; i++) begin
            radio_second();
            exp_s++;
            check("R2 R4 radio count", cur_hms, bcd_of(exp_s));
        end

        // R6, R10: preset to 23:58 with date A
        strobe(23, 58, DATE_A);
        check("R6 no load before tick", cur_hms, bcd_of(exp_s));
        @(negedge clk);
        dec_hr_t = 4'd1; dec_mn_u = 4'd2; dec_year = 8'h55;
        radio_second();
        exp_s = 23 * 3600 + 58 * 60;
        check("R6 R10 load time", cur_hms, bcd_of(exp_s));
        check("R6 R10 load date", cur_date, DATE_A);

        // R2, R3: run across midnight
        for (int i = 0; i < 130; i++) begin
            radio_second();
            exp_s = (exp_s + 1) % 86400;
            check("R3 midnight run", cur_hms, bcd_of(exp_s));
        end
        // R7: date untouched by rollover
        check("R7 date held", cur_date, DATE_A);

        // R8: early radio pulse ignored
        pulse50();
        rtick();
        check("R8 early pulse ignored", cur_hms, bcd_of(exp_s));
        repeat (GUARD - 1) pulse50();
        rtick();
        exp_s++;
        check("R8 pulse at guard accepted", cur_hms, bcd_of(exp_s));

        // R9, R5: loss of lock
        @(negedge clk) sync_ok = 1'b0;
        repeat (DIV - 1) pulse50();
        check("R9 no early backup", cur_hms, bcd_of(exp_s));
        rtick();
        check("R5 radio ignored", cur_hms, bcd_of(exp_s));
        pulse50();
        exp_s++;
        check("R9 first backup second", cur_hms, bcd_of(exp_s));
        for (int i = 0; i < 3; i++) begin
            repeat (DIV) pulse50();
            exp_s++;
            check("R5 backup count", cur_hms, bcd_of(exp_s));
        end

        // R6: preset applied on a backup second
        strobe(12, 34, DATE_B);
        repeat (DIV) pulse50();
        exp_s = 12 * 3600 + 34 * 60;
        check("R6 backup load", cur_hms, bcd_of(exp_s));
        check("R6 backup date", cur_date, DATE_B);

        // R8: return to lock just after a backup second
        @(negedge clk) sync_ok = 1'b1;
        repeat (GUARD - 1) pulse50();
        rtick();
        check("R8 no double on return", cur_hms, bcd_of(exp_s));
        pulse50();
        rtick();
        exp_s++;
        check("R8 radio resumes", cur_hms, bcd_of(exp_s));

        // R3: sweep every hour through its rollover
        for (int h = 0; h < 24; h++) begin
            strobe(h, 59, DATE_A);
            radio_second();
            exp_s = h * 3600 + 59 * 60;
            check("R6 sweep load", cur_hms, bcd_of(exp_s));
            for (int s = 0; s < 61; s++) begin
                radio_second();
                exp_s = (exp_s + 1) % 86400;
                check("R2 R3 hour sweep", cur_hms, bcd_of(exp_s));
            end
        end
        check("R7 date after sweep", cur_date, DATE_A);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule